// File: doc/BRIEF.md
# Randomized Montgomery Modular Exponentiator

This engine raises a message to an exponent modulo an odd modulus, c = m^e mod n, with every product formed by a word-serial Montgomery multiplier. The caller supplies the Montgomery constants: R mod n, R² mod n and the word inverse −n⁻¹ mod 2^W. The engine first moves the message into the Montgomery domain. It then walks the exponent from its top bit down, squaring the accumulator on every bit and multiplying by the transformed message when the bit is set. Finally it multiplies by one to return to the normal domain.

To blur the timing and power profile, a 16-bit LFSR is stepped once per exponent bit. On a zero bit whose fresh LFSR draw has its top bit set, the engine runs one extra multiplication and throws its product away. The operand length is chosen per run from five sizes, measured in W-bit words. With the default 32-bit word these are 192, 256, 512, 1024 and 2048 bits. A verification build may shrink the word width so that every mode stays small.

Top module: `rand_modexp`

## Requirements
- R1: While reset is high and after it is released, `done` is 0 and `result` is 0.
- R2: When n is odd, m < n, `r_mod` = 2^B mod n, `r2_mod` = 2^(2B) mod n and `nprime0` = −n⁻¹ mod 2^W, `result` equals m^e mod n when `done` is 1. B is the mode width in bits. This includes e = 0, e = 1 and m = 0.
- R3: The `mode` codes 0, 1, 2, 3 and 4 select 6, 8, 16, 32 and 64 words, so B = words × W. Codes 5 to 7 behave as code 4.
- R4: Bits of `msg`, `expo`, `modulus`, `r_mod` and `r2_mod` at or above position B do not change `result` or latency.
- R5: Let K = B + 2 + (ones in e below B) + (dummy multiplications), and let Nw be the mode's word count. `done` is 1 in the cycle that follows the K·(Nw+3)-th rising edge after the edge that samples `start`.
- R6: The LFSR is loaded from `seed` at start. For each exponent bit, highest first, the LFSR steps once with next = {s[14:0], s[15]^s[13]^s[12]^s[10]}. When the bit is 0 and the new s[15] is 1, one dummy multiplication is added. `result` does not depend on `seed`.
- R7: A `seed` of 0 behaves exactly as a seed of 1.
- R8: `done` is high for exactly one cycle. `result` holds its value until the next completion, including throughout the following run.
- R9: A `start` while a run is in progress is ignored. Mode and operands are sampled only at an accepted start, so later changes on those inputs do not affect the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, accepted only when idle |
| mode | input | 3 | Key-length select |
| msg | input | 64·WORD_W | Message m |
| expo | input | 64·WORD_W | Exponent e |
| modulus | input | 64·WORD_W | Odd modulus n |
| r_mod | input | 64·WORD_W | 2^B mod n |
| r2_mod | input | 64·WORD_W | 2^(2B) mod n |
| nprime0 | input | WORD_W | −n⁻¹ mod 2^W |
| seed | input | 16 | LFSR seed |
| result | output | 64·WORD_W | c = m^e mod n, held |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every multiplication takes exactly Nw+3 cycles, so the completion cycle of a run follows from the exponent's bit pattern and the seed's LFSR sequence. The bench computes this count K·(Nw+3) on its own and counts edges from the accepting edge. It samples on falling edges and requires `done` to appear on exactly that edge. A result or a done pulse that arrives one cycle early or late fails the check. Results are compared at that same sample against a square-and-multiply reference.

// File: rtl/rexp_pkg.sv
package rexp_pkg;

    localparam int MAX_WORDS = 64;
    localparam int SEED_W    = 16;

    typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_WAIT} ctl_state_e;
    typedef enum logic [1:0] {OP_ENTER, OP_SQUARE, OP_MULT, OP_LEAVE} mm_op_e;

    typedef struct packed {
        ctl_state_e st;
        mm_op_e     op;
        logic       dummy;
    } ctl_t;

    // key-length code to operand words
    function automatic logic [7:0] words_of(input logic [2:0] sel);
        case (sel)
            3'd0:    return 8'd6;
            3'd1:    return 8'd8;
            3'd2:    return 8'd16;
            3'd3:    return 8'd32;
            default: return 8'd64;
        endcase
    endfunction

    function automatic logic [SEED_W-1:0] seed_step(input logic [SEED_W-1:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/rexp_lfsr.sv
module rexp_lfsr
    import rexp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SEED_W-1:0] seed,
    input  logic              adv,
    output logic              peek_msb
);
    logic [SEED_W-1:0] s_q;
    logic [SEED_W-1:0] s_nxt;

    always_comb begin
        s_nxt    = seed_step(s_q);
        peek_msb = s_nxt[SEED_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst)       s_q <= SEED_W'(1);
        else if (load) s_q <= (seed == '0) ? SEED_W'(1) : seed;
        else if (adv)  s_q <= s_nxt;
    end

    // R7: an all-zero state would lock the sequence
    a_r7_never_zero: assert property (@(posedge clk) disable iff (rst) s_q != '0);

endmodule

// File: rtl/rexp_montmul.sv
module rexp_montmul
    import rexp_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int MAXB   = WORD_W * MAX_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [7:0]        nwords,
    input  logic [MAXB-1:0]   op_a,
    input  logic [MAXB-1:0]   op_b,
    input  logic [MAXB-1:0]   modn,
    input  logic [WORD_W-1:0] nprime,
    output logic [MAXB-1:0]   prod,
    output logic              fin,
    output logic              busy
);
    localparam int SW = MAXB + WORD_W + 2;
    localparam int TW = MAXB + 2;
    localparam int QW = 2 * WORD_W;

    logic [TW-1:0]     t_q;
    logic [MAXB-1:0]   a_q, b_q, n_q, prod_q;
    logic [WORD_W-1:0] np_q;
    logic [7:0]        nw_q, cnt_q;
    logic              busy_q, fin_q;

    logic [WORD_W-1:0] a_word, q_word;
    logic [QW-1:0]     q_full;
    logic [SW-1:0]     s0, s1;
    logic [TW-1:0]     t_next, t_fix;

    always_comb begin
        a_word = a_q[WORD_W-1:0];
        s0     = SW'(t_q) + SW'(a_word) * SW'(b_q);
        q_full = QW'(s0[WORD_W-1:0]) * QW'(np_q);
        q_word = q_full[WORD_W-1:0];
        s1     = s0 + SW'(q_word) * SW'(n_q);
        t_next = s1[SW-1:WORD_W];
        t_fix  = (t_q >= TW'(n_q)) ? (t_q - TW'(n_q)) : t_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= '0; a_q <= '0; b_q <= '0; n_q <= '0; prod_q <= '0;
            np_q <= '0; nw_q <= '0; cnt_q <= '0; busy_q <= 1'b0; fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go && !busy_q) begin
                a_q <= op_a; b_q <= op_b; n_q <= modn; np_q <= nprime;
                nw_q <= nwords; t_q <= '0; cnt_q <= '0; busy_q <= 1'b1;
            end else if (busy_q) begin
                if (cnt_q != nw_q) begin
                    t_q   <= t_next;
                    a_q   <= a_q >> WORD_W;
                    cnt_q <= cnt_q + 8'd1;
                end else begin
                    prod_q <= t_fix[MAXB-1:0];
                    busy_q <= 1'b0;
                    fin_q  <= 1'b1;
                end
            end
        end
    end

    assign prod = prod_q;
    assign fin  = fin_q;
    assign busy = busy_q;

    // R2: every product leaves the multiplier fully reduced
    a_r2_reduced: assert property (@(posedge clk) disable iff (rst) fin_q |-> (prod_q < n_q));
    // R5: the controller never launches into a busy multiplier
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst) go |-> !busy_q);

endmodule

// File: rtl/rand_modexp.sv
module rand_modexp
    import rexp_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [2:0]                  mode,
    input  logic [WORD_W*MAX_WORDS-1:0] msg,
    input  logic [WORD_W*MAX_WORDS-1:0] expo,
    input  logic [WORD_W*MAX_WORDS-1:0] modulus,
    input  logic [WORD_W*MAX_WORDS-1:0] r_mod,
    input  logic [WORD_W*MAX_WORDS-1:0] r2_mod,
    input  logic [WORD_W-1:0]           nprime0,
    input  logic [SEED_W-1:0]           seed,
    output logic [WORD_W*MAX_WORDS-1:0] result,
    output logic                        done
);
    localparam int MAXB = WORD_W * MAX_WORDS;
    localparam int IW   = $clog2(MAXB);
    localparam int BW   = IW + 1;

    ctl_t              ctl_q;
    logic [IW-1:0]     idx_q;
    logic [7:0]        nw_q;
    logic [MAXB-1:0]   m_q, e_q, n_q, r2_q, acc_q, mm_q, res_q;
    logic [WORD_W-1:0] np_q;
    logic              done_q;

    logic [7:0]        words_c;
    logic [BW-1:0]     bits_c;
    logic [MAXB-1:0]   mask_c, mul_a, mul_b, mul_p;
    logic              go, mfin, mbusy, draw, lfsr_load, lfsr_adv, last_bit;

    always_comb begin
        words_c  = words_of(mode);
        bits_c   = BW'(words_c) * BW'(WORD_W);
        mask_c   = ~({MAXB{1'b1}} << bits_c);
        go       = (ctl_q.st == ST_LAUNCH);
        last_bit = (idx_q == '0);
        lfsr_load = (ctl_q.st == ST_IDLE) && start;
        lfsr_adv  = (ctl_q.st == ST_WAIT) && mfin && (ctl_q.op == OP_SQUARE);
        case (ctl_q.op)
            OP_ENTER:  begin mul_a = m_q;   mul_b = r2_q;         end
            OP_SQUARE: begin mul_a = acc_q; mul_b = acc_q;        end
            OP_MULT:   begin mul_a = acc_q; mul_b = mm_q;         end
            default:   begin mul_a = acc_q; mul_b = MAXB'(1);     end
        endcase
    end

    rexp_montmul #(.WORD_W(WORD_W), .MAXB(MAXB)) u_mul (
        .clk(clk), .rst(rst), .go(go), .nwords(nw_q),
        .op_a(mul_a), .op_b(mul_b), .modn(n_q), .nprime(np_q),
        .prod(mul_p), .fin(mfin), .busy(mbusy)
    );

    rexp_lfsr u_lfsr (
        .clk(clk), .rst(rst), .load(lfsr_load), .seed(seed),
        .adv(lfsr_adv), .peek_msb(draw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{st: ST_IDLE, op: OP_ENTER, dummy: 1'b0};
            idx_q <= '0; nw_q <= '0; np_q <= '0;
            m_q <= '0; e_q <= '0; n_q <= '0; r2_q <= '0;
            acc_q <= '0; mm_q <= '0; res_q <= '0; done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (ctl_q.st)
                ST_IDLE: if (start) begin
                    nw_q  <= words_c;
                    m_q   <= msg & mask_c;
                    e_q   <= expo & mask_c;
                    n_q   <= modulus & mask_c;
                    r2_q  <= r2_mod & mask_c;
                    acc_q <= r_mod & mask_c;
                    np_q  <= nprime0;
                    idx_q <= IW'(bits_c - BW'(1));
                    ctl_q <= '{st: ST_LAUNCH, op: OP_ENTER, dummy: 1'b0};
                end
                ST_LAUNCH: ctl_q.st <= ST_WAIT;
                default: if (mfin) begin
                    ctl_q.st <= ST_LAUNCH;
                    case (ctl_q.op)
                        OP_ENTER: begin
                            mm_q     <= mul_p;
                            ctl_q.op <= OP_SQUARE;
                        end
                        OP_SQUARE: begin
                            acc_q <= mul_p;
                            if (e_q[idx_q] || draw) begin
                                ctl_q.op    <= OP_MULT;
                                ctl_q.dummy <= !e_q[idx_q];
                            end else if (last_bit) begin
                                ctl_q.op <= OP_LEAVE;
                            end else begin
                                idx_q <= idx_q - IW'(1);
                            end
                        end
                        OP_MULT: begin
                            if (!ctl_q.dummy) acc_q <= mul_p;
                            if (last_bit) ctl_q.op <= OP_LEAVE;
                            else begin
                                idx_q    <= idx_q - IW'(1);
                                ctl_q.op <= OP_SQUARE;
                            end
                        end
                        default: begin
                            res_q    <= mul_p;
                            done_q   <= 1'b1;
                            ctl_q.st <= ST_IDLE;
                        end
                    endcase
                end
            endcase
        end
    end

    assign result = res_q;
    assign done   = done_q;

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst) done_q |=> !done_q);
    // R9: a start during a run leaves the sampled operands untouched
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st != ST_IDLE) && start |=> $stable(e_q) && $stable(n_q) && $stable(nw_q));
    // R3: an accepted start always selects one of the five widths
    a_r3_mode_words: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == ST_IDLE) && start |=>
        (nw_q == 8'd6 || nw_q == 8'd8 || nw_q == 8'd16 || nw_q == 8'd32 || nw_q == 8'd64));

endmodule

// File: tb/rand_modexp_test.sv
module rand_modexp_test;
    localparam int W  = 4;
    localparam int MB = W * 64;
    typedef logic [511:0] wide_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [2:0] mode = 3'd0;
    logic [MB-1:0] msg = '0, expo = '0, modulus = '0, r_mod = '0, r2_mod = '0;
    logic [W-1:0] nprime0 = '0;
    logic [15:0] seed = 16'd1;
    logic [MB-1:0] result;
    logic done;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    rand_modexp #(.WORD_W(W)) uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .msg(msg), .expo(expo),
        .modulus(modulus), .r_mod(r_mod), .r2_mod(r2_mod), .nprime0(nprime0),
        .seed(seed), .result(result), .done(done)
    );

    function automatic int words_for(input int md);
        case (md)
            0: return 6;
            1: return 8;
            2: return 16;
            3: return 32;
            default: return 64;
        endcase
    endfunction

    function automatic wide_t wmask(input int bits);
        return (wide_t'(1) << bits) - wide_t'(1);
    endfunction

    function automatic wide_t pow2mod(input int k, input wide_t n);
        wide_t x = wide_t'(1) % n;
        for (int i = 0; i < k; i++) x = (x << 1) % n;
        return x;
    endfunction

    function automatic wide_t ref_modexp(input wide_t m, input wide_t e, input wide_t n, input int bits);
        wide_t r = wide_t'(1) % n;
        for (int i = bits - 1; i >= 0; i--) begin
            r = (r * r) % n;
            if (e[i]) r = (r * m) % n;
        end
        return r;
    endfunction

    function automatic logic [W-1:0] calc_np(input logic [W-1:0] n0);
        logic [W-1:0] inv = 1;
        for (int i = 0; i < 6; i++) inv = W'(inv * (W'(2) - W'(n0 * inv)));
        return W'(0) - inv;
    endfunction

    function automatic logic [15:0] lstep(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic int exp_latency(input int md, input wide_t e, input logic [15:0] sd);
        int nw = words_for(md);
        int bits = nw * W;
        int k = bits + 2;
        logic [15:0] s = (sd == 16'd0) ? 16'd1 : sd;
        for (int i = bits - 1; i >= 0; i--) begin
            s = lstep(s);
            if (e[i]) k++;
            else if (s[15]) k++;
        end
        return k * (nw + 3);
    endfunction

    function automatic wide_t rnd(input int bits);
        wide_t x = '0;
        for (int i = 0; i < 16; i++) x = (x << 32) | wide_t'($urandom);
        return x & wmask(bits);
    endfunction

    task automatic chk(input string req, input wide_t act, input wide_t expv);
        total++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    // one run; optional junk above the mode width and optional disturbance mid-run
    task automatic run(input int md, input wide_t m, input wide_t e, input wide_t n,
                       input logic [15:0] sd, input wide_t junk, input bit disturb,
                       input wide_t held, output wide_t res, output int cyc);
        int bits = words_for(md) * W;
        wide_t hi = junk & ~wmask(bits);
        @(negedge clk);
        mode    = 3'(md);
        msg     = MB'(m | hi);
        expo    = MB'(e | hi);
        modulus = MB'(n | hi);
        r_mod   = MB'(pow2mod(bits, n) | hi);
        r2_mod  = MB'(pow2mod(2 * bits, n) | hi);
        nprime0 = calc_np(n[W-1:0]);
        seed    = sd;
        start   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (disturb && cyc == 10) begin
                chk("R8 result held during next run", wide_t'(result), held);
                start = 1'b1;
                msg = ~msg; expo = ~expo; modulus = ~modulus; mode = 3'd0; seed = ~seed;
            end
            if (disturb && cyc == 11) start = 1'b0;
            if (done || cyc > 120000) break;
        end
        res = wide_t'(result);
    endtask

    task automatic full_check(input string tag, input int md, input wide_t m, input wide_t e,
                              input wide_t n, input logic [15:0] sd);
        wide_t res;
        int cyc;
        int bits = words_for(md) * W;
        run(md, m, e, n, sd, '0, 1'b0, '0, res, cyc);
        chk({tag, " R2 result"}, res, ref_modexp(m, e, n, bits));
        chk({tag, " R5 latency"}, wide_t'(cyc), wide_t'(exp_latency(md, e, sd)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        wide_t n, m, e, res_a, res_b, held;
        int cyc_a, cyc_b;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 done in reset", wide_t'(done), '0);
        chk("R1 result in reset", wide_t'(result), '0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done after reset", wide_t'(done), '0);
        chk("R1 result after reset", wide_t'(result), '0);

        // directed corners, mode 0 (24 bits)
        n = rnd(24) | wide_t'(1) | (wide_t'(1) << 23);
        m = rnd(24) % n;
        full_check("e=0",  0, m, '0, n, 16'h1ACE);
        full_check("e=1",  0, m, wide_t'(1), n, 16'h1ACE);
        full_check("m=0",  0, '0, rnd(24), n, 16'h0BAD);
        full_check("e=all ones", 0, m, wmask(24), n, 16'h5EED);

        // random operands across modes (R3 widths)
        for (int md = 0; md < 4; md++) begin
            for (int k = 0; k < 4 - md / 2; k++) begin
                int bits = words_for(md) * W;
                n = rnd(bits) | wide_t'(1) | (wide_t'(1) << (bits - 1));
                m = rnd(bits) % n;
                e = rnd(bits);
                full_check("R3 random", md, m, e, n, 16'($urandom));
            end
        end
        n = rnd(256) | wide_t'(1) | (wide_t'(1) << 255);
        m = rnd(256) % n;
        e = rnd(256);
        full_check("R3 mode 4", 4, m, e, n, 16'hC0DE);
        full_check("R3 code 7 as widest", 7, m, e, n, 16'hC0DE);

        // R6: sparse exponent, two seeds
        n = rnd(32) | wide_t'(1) | (wide_t'(1) << 31);
        m = rnd(32) % n;
        e = wide_t'(32'h8000_0101);
        run(1, m, e, n, 16'hACE1, '0, 1'b0, '0, res_a, cyc_a);
        run(1, m, e, n, 16'h0F0F, '0, 1'b0, '0, res_b, cyc_b);
        chk("R6 same result for two seeds", res_a, res_b);
        chk("R6 dummy count seed A", wide_t'(cyc_a), wide_t'(exp_latency(1, e, 16'hACE1)));
        chk("R6 dummy count seed B", wide_t'(cyc_b), wide_t'(exp_latency(1, e, 16'h0F0F)));

        // R7: zero seed equals seed one
        run(1, m, e, n, 16'h0000, '0, 1'b0, '0, res_a, cyc_a);
        run(1, m, e, n, 16'h0001, '0, 1'b0, '0, res_b, cyc_b);
        chk("R7 zero seed latency", wide_t'(cyc_a), wide_t'(cyc_b));
        chk("R7 zero seed result", res_a, res_b);

        // R4: junk above the mode width
        n = rnd(24) | wide_t'(1) | (wide_t'(1) << 23);
        m = rnd(24) % n;
        e = rnd(24);
        run(0, m, e, n, 16'h3333, {16{32'hDEAD_BEEF}}, 1'b0, '0, res_a, cyc_a);
        chk("R4 junk ignored result", res_a, ref_modexp(m, e, n, 24));
        chk("R4 junk ignored latency", wide_t'(cyc_a), wide_t'(exp_latency(0, e, 16'h3333)));

        // R8: pulse width and hold
        held = res_a;
        repeat (5) @(negedge clk);
        chk("R8 done single cycle", wide_t'(done), '0);
        chk("R8 result held idle", wide_t'(result), held);

        // R9: start and input changes mid-run are ignored
        n = rnd(64) | wide_t'(1) | (wide_t'(1) << 63);
        m = rnd(64) % n;
        e = rnd(64);
        run(2, m, e, n, 16'h7777, '0, 1'b1, held, res_b, cyc_b);
        chk("R9 busy start result", res_b, ref_modexp(m, e, n, 64));
        chk("R9 busy start latency", wide_t'(cyc_b), wide_t'(exp_latency(2, e, 16'h7777)));

        summary();
        $finish;
    end
endmodule